// File: doc/BRIEF.md
# Bit-Banged Serial Configuration EEPROM Slave

This block models a small serial configuration memory of 64 words of 16 bits, reached by software through a single control register. The host moves the serial clock, select and data-in lines by writing that register. It samples the data-out line by reading the register back. No clock runs on the serial side. A serial clock edge is any register write whose clock bit differs from the value written before it.

While select is high, rising edges shift in a nine-bit command: a three-bit opcode followed by a six-bit word address. Only the read opcode does anything. After a read command, each falling edge advances an output bit pointer. The data-out line then walks the memory MSB first. It carries on from the end of one word into the start of the next, and from the last word back to word 0, until select is dropped. A rising edge with select low returns the serial logic to idle. The memory image is loaded from a parameter at reset and never changes after that.

Top module: `mw_eeprom_slave`

## Requirements
- R1: After reset the register reads 0x68. Clock, select, data-in and request read 0. Data-out reads 1, and the grant and present flags read 1.
- R2: Register layout: bit 0 clock, bit 1 select, bit 2 data-in, bit 3 data-out (read only), bit 4 request, bit 5 grant, bit 6 present, bit 7 zero. A read returns the last written clock, select, data-in and request values. Grant and present always read 1.
- R3: A write whose clock bit equals the stored clock bit updates only the stored line values. The shift state, the bit pointer and the read flag are left as they were.
- R4: A rising edge with select high shifts data-in into the command shifter. When the ninth bit arrives and no read is active, bits [8:6] are the opcode and bits [5:0] are the address. A read starts only for opcode 3'b110.
- R5: After a read command, the first falling edge makes data-out show bit 15 of the addressed word. Each later falling edge moves one bit lower.
- R6: After bit 0 of a word, the next falling edge shows bit 15 of the following word. Word 63 is followed by word 0.
- R7: A rising edge with select low clears the shifter, the bit counter, the pointer and the read flag. Data-out then reads 1, and a new command is accepted.
- R8: The opcodes 3'b000, 3'b100, 3'b101 and 3'b111 start nothing: data-out stays 1 and the memory content is unchanged.
- R9: Bits shifted in after the ninth are ignored until the next deselect. Once a read is running, they do not disturb the output stream. After a non-read command, they cannot start a read.
- R10: The default image holds word i = ((i * 0x1F3B) ^ 0xC5A0) mod 2^16.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset; loads the memory image |
| reg_we | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write value |
| reg_rdata | output | 8 | Control register read value, including the derived data-out bit |

## Verification
The bench builds the block with its default values: 64 words of 16 bits and the computed default image. With these, the 10-bit output pointer rolls over from word 63 to word 0 within a few dozen serial clocks, so the wrap case is easy to reach. The nine-bit command length also lets every opcode class be sent directly. Because the image follows a simple formula, the bench can predict any word at any address, and reads that run across two words can be checked bit for bit.

// File: rtl/mw_eeprom_pkg.sv
`timescale 1ns/1ps
package mw_eeprom_pkg;

    localparam int CTL_W  = 8;
    localparam int B_SK   = 0;
    localparam int B_CS   = 1;
    localparam int B_DI   = 2;
    localparam int B_DO   = 3;
    localparam int B_REQ  = 4;
    localparam int B_GNT  = 5;
    localparam int B_PRES = 6;

    localparam int OP_W = 3;
    localparam logic [OP_W-1:0] OP_READ = 3'b110;

    localparam int DEF_WORDS  = 64;
    localparam int DEF_WORD_W = 16;

    typedef enum logic [1:0] {
        SK_NONE = 2'd0,
        SK_FALL = 2'd1,
        SK_RISE = 2'd2
    } sk_event_e;

    function automatic logic [DEF_WORDS*DEF_WORD_W-1:0] default_image();
        logic [DEF_WORDS*DEF_WORD_W-1:0] img;
        for (int i = 0; i < DEF_WORDS; i++) begin
            img[i*DEF_WORD_W +: DEF_WORD_W] = DEF_WORD_W'((i * 32'h1F3B) ^ 32'hC5A0);
        end
        return img;
    endfunction

endpackage

// File: rtl/mw_sk_edge.sv
`timescale 1ns/1ps
module mw_sk_edge
    import mw_eeprom_pkg::*;
(
    input  logic      we,
    input  logic      sk_prev,
    input  logic      sk_new,
    output sk_event_e ev
);
    always_comb begin
        ev = SK_NONE;
        if (we && (sk_prev != sk_new)) begin
            ev = sk_new ? SK_RISE : SK_FALL;
        end
    end
endmodule

// File: rtl/mw_word_store.sv
`timescale 1ns/1ps
module mw_word_store #(
    parameter int WORDS  = 64,
    parameter int WORD_W = 16,
    parameter logic [WORDS*WORD_W-1:0] INIT = '0,
    localparam int ADDR_W = $clog2(WORDS),
    localparam int BIT_W  = $clog2(WORD_W),
    localparam int PTR_W  = ADDR_W + BIT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PTR_W-1:0] ptr,
    output logic             bit_o
);
    logic [WORD_W-1:0] words [WORDS];

    for (genvar w = 0; w < WORDS; w++) begin : g_word
        logic [WORD_W-1:0] word_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) word_q <= INIT[w*WORD_W +: WORD_W];
            else        word_q <= word_q;
        end
        assign words[w] = word_q;
    end

    // Pointer low bits count up while the bit index counts down: MSB first.
    always_comb begin
        bit_o = words[ptr[PTR_W-1 -: ADDR_W]][~ptr[BIT_W-1:0]];
    end
endmodule

// File: rtl/mw_eeprom_slave.sv
`timescale 1ns/1ps
module mw_eeprom_slave
    import mw_eeprom_pkg::*;
#(
    parameter int WORDS  = DEF_WORDS,
    parameter int WORD_W = DEF_WORD_W,
    parameter logic [WORDS*WORD_W-1:0] INIT = default_image()
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [CTL_W-1:0] reg_wdata,
    output logic [CTL_W-1:0] reg_rdata
);
    localparam int ADDR_W  = $clog2(WORDS);
    localparam int BIT_W   = $clog2(WORD_W);
    localparam int PTR_W   = ADDR_W + BIT_W;
    localparam int CMD_LEN = OP_W + ADDR_W;
    localparam int CNT_W   = $clog2(CMD_LEN + 1);

    typedef struct packed {
        logic               sk;
        logic               cs;
        logic               di;
        logic               req;
        logic [CMD_LEN-1:0] shift;
        logic [CNT_W-1:0]   cnt;
        logic [PTR_W-1:0]   ptr;
        logic               reading;
    } state_t;

    state_t             st_d, st_q;
    sk_event_e          sk_ev;
    logic               mem_bit;
    logic [CMD_LEN-1:0] shift_n;
    logic [CNT_W-1:0]   cnt_n;

    mw_sk_edge u_edge (
        .we      (reg_we),
        .sk_prev (st_q.sk),
        .sk_new  (reg_wdata[B_SK]),
        .ev      (sk_ev)
    );

    mw_word_store #(
        .WORDS  (WORDS),
        .WORD_W (WORD_W),
        .INIT   (INIT)
    ) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .ptr   (st_q.ptr),
        .bit_o (mem_bit)
    );

    always_comb begin
        st_d    = st_q;
        shift_n = {st_q.shift[CMD_LEN-2:0], reg_wdata[B_DI]};
        cnt_n   = (st_q.cnt == {CNT_W{1'b1}}) ? st_q.cnt : st_q.cnt + CNT_W'(1);
        if (reg_we) begin
            st_d.sk  = reg_wdata[B_SK];
            st_d.cs  = reg_wdata[B_CS];
            st_d.di  = reg_wdata[B_DI];
            st_d.req = reg_wdata[B_REQ];
            case (sk_ev)
                SK_FALL: st_d.ptr = st_q.ptr + PTR_W'(1);
                SK_RISE: begin
                    if (!reg_wdata[B_CS]) begin
                        st_d.shift   = '0;
                        st_d.cnt     = '0;
                        st_d.ptr     = '0;
                        st_d.reading = 1'b0;
                    end else begin
                        st_d.shift = shift_n;
                        st_d.cnt   = cnt_n;
                        if ((cnt_n == CNT_W'(CMD_LEN)) && !st_q.reading) begin
                            st_d.ptr     = {shift_n[ADDR_W-1:0], {BIT_W{1'b0}}} - PTR_W'(1);
                            st_d.reading = (shift_n[CMD_LEN-1 -: OP_W] == OP_READ);
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        reg_rdata         = '0;
        reg_rdata[B_SK]   = st_q.sk;
        reg_rdata[B_CS]   = st_q.cs;
        reg_rdata[B_DI]   = st_q.di;
        reg_rdata[B_REQ]  = st_q.req;
        reg_rdata[B_DO]   = st_q.reading ? mem_bit : 1'b1;
        reg_rdata[B_GNT]  = 1'b1;
        reg_rdata[B_PRES] = 1'b1;
    end
endmodule

// File: rtl/mw_eeprom_slave_chk.sv
`timescale 1ns/1ps
module mw_eeprom_slave_chk #(
    parameter int PTR_W = 10,
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_we,
    input logic [7:0]       reg_wdata,
    input logic [7:0]       reg_rdata,
    input logic             sk_q,
    input logic [PTR_W-1:0] ptr_q,
    input logic [CNT_W-1:0] cnt_q,
    input logic             reading_q
);
    assert_flags_R2: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[5] && reg_rdata[6] && !reg_rdata[7]);

    assert_idle_do_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !reading_q |-> reg_rdata[3]);

    assert_fall_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && sk_q && !reg_wdata[0]) |=> (ptr_q == PTR_W'($past(ptr_q) + PTR_W'(1))));

    assert_no_edge_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && (reg_wdata[0] == sk_q)) |=>
            ($stable(ptr_q) && $stable(cnt_q) && $stable(reading_q)));

    assert_deselect_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && !sk_q && reg_wdata[0] && !reg_wdata[1]) |=>
            ((cnt_q == '0) && (ptr_q == '0) && !reading_q));

    assert_quiet_bus_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_we |=> ($stable(ptr_q) && $stable(cnt_q) && $stable(reading_q)));
endmodule

bind mw_eeprom_slave mw_eeprom_slave_chk #(
    .PTR_W (PTR_W),
    .CNT_W (CNT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .sk_q      (st_q.sk),
    .ptr_q     (st_q.ptr),
    .cnt_q     (st_q.cnt),
    .reading_q (st_q.reading)
);

// File: tb/mw_eeprom_slave_bench.sv
`timescale 1ns/1ps
module mw_eeprom_slave_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_we = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    mw_eeprom_slave u_mw_eeprom_slave (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata)
    );

    // {opcode[2:0], address[5:0]}
    localparam logic [8:0] VEC [8] = '{
        {3'b110, 6'd0},  {3'b110, 6'd1},  {3'b110, 6'd37}, {3'b110, 6'd62},
        {3'b101, 6'd5},  {3'b111, 6'd5},  {3'b100, 6'd48}, {3'b000, 6'd9}
    };

    function automatic logic [15:0] ref_word(int i);
        return 16'(((i % 64) * 32'h1F3B) ^ 32'hC5A0);
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(logic sk, logic cs, logic di, logic req);
        @(negedge clk);
        reg_we    = 1'b1;
        reg_wdata = {3'b000, req, 1'b0, di, cs, sk};
        @(negedge clk);
        reg_we    = 1'b0;
    endtask

    task automatic deselect();
        wr(1'b0, 1'b0, 1'b0, 1'b0);
        wr(1'b1, 1'b0, 1'b0, 1'b0);
        wr(1'b0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic shift_bits(logic [8:0] bits);
        for (int i = 8; i >= 0; i--) begin
            wr(1'b0, 1'b1, bits[i], 1'b0);
            wr(1'b1, 1'b1, bits[i], 1'b0);
        end
    endtask

    // DI held at 1 on the rising edges during a read (R9).
    task automatic read_bits(int n, output logic [31:0] v);
        v = '0;
        for (int i = 0; i < n; i++) begin
            wr(1'b0, 1'b1, 1'b0, 1'b0);
            v = {v[30:0], reg_rdata[3]};
            wr(1'b1, 1'b1, 1'b1, 1'b0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] a, b;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset image
        chk("R1 reset readback", 32'(reg_rdata), 32'h68);

        // R2 line readback without an edge
        wr(1'b0, 1'b1, 1'b1, 1'b1);
        chk("R2 line readback", 32'(reg_rdata), 32'h7E);
        deselect();

        // Table walk: R4, R5, R6, R8, R10
        for (int k = 0; k < 8; k++) begin
            automatic logic [8:0] v = VEC[k];
            automatic bit is_rd = (v[8:6] == 3'b110);
            wr(1'b0, 1'b1, 1'b0, 1'b0);
            shift_bits(v);
            read_bits(16, a);
            read_bits(16, b);
            chk(is_rd ? "R5 R10 first word" : "R8 no read",
                a, is_rd ? 32'(ref_word(int'(v[5:0]))) : 32'hFFFF);
            chk(is_rd ? "R6 next word" : "R8 stays high",
                b, is_rd ? 32'(ref_word(int'(v[5:0]) + 1)) : 32'hFFFF);
            deselect();
        end

        // R6 wrap from the last word to word 0
        wr(1'b0, 1'b1, 1'b0, 1'b0);
        shift_bits({3'b110, 6'd63});
        read_bits(16, a);
        read_bits(16, b);
        chk("R6 word 63", a, 32'(ref_word(63)));
        chk("R6 wrap to word 0", b, 32'(ref_word(0)));
        deselect();

        // R3 writes with unchanged clock in the middle of a read
        wr(1'b0, 1'b1, 1'b0, 1'b0);
        shift_bits({3'b110, 6'd10});
        read_bits(8, a);
        wr(1'b1, 1'b1, 1'b0, 1'b1);
        chk("R3 req stored", 32'(reg_rdata[4]), 32'h1);
        wr(1'b1, 1'b1, 1'b1, 1'b0);
        wr(1'b1, 1'b1, 1'b0, 1'b0);
        read_bits(8, b);
        chk("R3 stream intact", {16'h0, a[7:0], b[7:0]}, 32'(ref_word(10)));
        deselect();

        // R7 abort mid-read, then a fresh command
        wr(1'b0, 1'b1, 1'b0, 1'b0);
        shift_bits({3'b110, 6'd20});
        read_bits(4, a);
        deselect();
        chk("R7 DO idle after deselect", 32'(reg_rdata[3]), 32'h1);
        wr(1'b0, 1'b1, 1'b0, 1'b0);
        shift_bits({3'b110, 6'd21});
        read_bits(16, a);
        chk("R7 new command", a, 32'(ref_word(21)));
        deselect();

        // R8 contents unchanged after write/erase opcodes at address 5
        wr(1'b0, 1'b1, 1'b0, 1'b0);
        shift_bits({3'b110, 6'd5});
        read_bits(16, a);
        chk("R8 word 5 unchanged", a, 32'(ref_word(5)));
        deselect();

        // R9 bits after a non-read command cannot start a read
        wr(1'b0, 1'b1, 1'b0, 1'b0);
        shift_bits({3'b000, 6'd0});
        shift_bits({3'b110, 6'd3});
        read_bits(16, a);
        chk("R9 late read opcode ignored", a, 32'hFFFF);
        deselect();

        // R4 eight bits only: no read yet
        wr(1'b0, 1'b1, 1'b0, 1'b0);
        for (int i = 8; i >= 1; i--) begin
            wr(1'b0, 1'b1, ((9'b110_000111 >> i) & 9'd1) != 0, 1'b0);
            wr(1'b1, 1'b1, ((9'b110_000111 >> i) & 9'd1) != 0, 1'b0);
        end
        wr(1'b0, 1'b1, 1'b0, 1'b0);
        chk("R4 no start before ninth bit", 32'(reg_rdata[3]), 32'h1);
        wr(1'b1, 1'b1, 1'b1, 1'b0);
        read_bits(16, a);
        chk("R4 ninth bit starts read", a, 32'(ref_word(7)));
        deselect();

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule